// File: doc/BRIEF.md
# Burst-of-Four Separate-Port SRAM Core

This block is a synthesizable behavioural model of a quad-data-rate memory core. It has one shared address bus, a write data port and a read data port. Every command moves a fixed burst of four words. A single clock runs at the data-beat rate. A phase input marks each cycle as belonging to the positive or the negative half of the external input clock, so one input-clock period covers two beat-rate edges.

Read and write requests are active low and are sampled only on positive-phase edges. Each request latches the burst base address at that edge. Write beats arrive late, starting two edges after the request. Read beats leave the core three edges after the request. Each of the four words has its own byte-lane enables, active low, and each lane is 9 bits wide. A read beat always returns the most current contents of its address, even when a write beat lands on that address at the same edge. When no read beat is being driven, the output-valid flag is low and the data bus is held at zero.

A small parameterised array stands in for a full-size memory. The address width, the number of lanes and the lane width are parameters.

Top module: `quad_burst_sram`

## Requirements
- R1: While reset is asserted, and after it until a read burst starts, `q_oe_o` is 0 and `q_o` is all zeros.
- R2: Read and write requests are honoured only at edges where `k_pos_i` is 1. A request asserted at an edge where `k_pos_i` is 0 has no effect.
- R3: A request that is accepted at one positive-phase edge locks out a request of the same type at the next positive-phase edge, two cycles later. The locked-out request is ignored. The lockout does not stop a request of the other type.
- R4: A write accepted at edge E captures `d_i` and `be_n_i` at edges E+2, E+3, E+4 and E+5, for addresses base, base+1, base+2 and base+3.
- R5: A read accepted at edge E drives its four beats for addresses base to base+3 on `q_o` after edges E+3 to E+6. `q_oe_o` is 1 for exactly those cycles, unless another burst follows directly.
- R6: `be_n_i[i]` low enables lane i, which is bits 9i to 9i+8 of a word. A lane whose enable is high keeps its stored value. All enables high writes nothing.
- R7: A read beat returns the array contents as they stand after any write beat captured at the same edge, merged lane by lane. Lanes that this write does not enable return the old contents.
- R8: When `q_oe_o` is 0, `q_o` is zero. `q_oe_o` falls in the cycle after the last beat of a burst when no other burst follows.
- R9: Burst addresses wrap modulo the array depth. For example, base 62 in a 64-word array gives 62, 63, 0, 1.
- R10: `d_i` and `be_n_i` have no effect in cycles that are not write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| k_pos_i | input | 1 | 1 when the coming edge is a positive input-clock edge; alternates every cycle |
| rd_n_i | input | 1 | Read request, active low |
| wr_n_i | input | 1 | Write request, active low |
| addr_i | input | AW | Burst base address, shared by reads and writes |
| d_i | input | LANES*LANE_W | Write data beat |
| be_n_i | input | LANES | Per-lane write enables, active low |
| q_o | output | LANES*LANE_W | Read data beat, zero when idle |
| q_oe_o | output | 1 | High while a read beat is driven |

## Verification
First, directed writes fill the whole array with known data. Then directed sequences check the following cases:
- Read and write requests that alternate on the shared bus, which separates the late-write offset from the read latency.
- Requests raised on the negative phase, and same-type requests on back-to-back positive edges, which show that the phase gating and the lockout drop exactly the intended command.
- Fixed lane-enable patterns, including all disabled, which show the lane-to-bit mapping.
- A read at base B followed by a write at B+1, which places a write beat on the same edge as a read beat of the same address and so exposes any missing or lane-blind forwarding.
- A burst based near the top of the array, which shows the address wrap.

A seeded random mix of reads, writes, shared addresses and lane enables follows. Meanwhile, random data and enables are driven on every non-beat cycle, so any leak from outside the write window would show.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
   // words moved by every command
   localparam int unsigned BURST_LEN = 4;
   // cycles from accept edge to the edge that arms the beat counter
   localparam int unsigned WR_LEAD = 1;
   localparam int unsigned RD_LEAD = 2;

   function automatic int unsigned lane_lo(input int unsigned lane, input int unsigned lane_w);
      return lane * lane_w;
   endfunction
endpackage

// File: rtl/qbs_burst_seq.sv
module qbs_burst_seq #(
   parameter int unsigned AW   = 6,
   parameter int unsigned LEAD = 1,
   parameter int unsigned BLEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          k_pos,
   input  logic          cmd_n,
   input  logic [AW-1:0] addr,
   output logic          beat_en,
   output logic [AW-1:0] beat_addr
);
   localparam int unsigned LW = $clog2(LEAD + 1);
   localparam int unsigned CW = $clog2(BLEN + 1);

   if (LEAD < 1 || LEAD >= BLEN) begin : g_bad_lead
      $error("qbs_burst_seq: LEAD must be in 1..BLEN-1");
   end

   logic          lock_q;
   logic          acc;
   logic [AW-1:0] base_q;
   logic [AW-1:0] ptr_q;
   logic [LW-1:0] lead_q;
   logic [CW-1:0] left_q;

   assign acc       = k_pos & ~cmd_n & ~lock_q;
   assign beat_en   = (left_q != '0);
   assign beat_addr = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         base_q <= '0;
         ptr_q  <= '0;
         lead_q <= '0;
         left_q <= '0;
      end else begin
         if (k_pos) lock_q <= acc;
         if (acc) begin
            base_q <= addr;
            lead_q <= LW'(LEAD);
         end else if (lead_q != '0) begin
            lead_q <= lead_q - LW'(1);
         end
         if (lead_q == LW'(1)) begin
            ptr_q  <= base_q;
            left_q <= CW'(BLEN);
         end else if (left_q != '0) begin
            ptr_q  <= ptr_q + AW'(1);
            left_q <= left_q - CW'(1);
         end
      end
   end

   // R3
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !acc ##1 !acc);

   // R4 R5
   lead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> ##(LEAD + 1) beat_en);

   // R4 R5
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(beat_en) |=> beat_en ##1 beat_en ##1 beat_en);
endmodule

// File: rtl/qbs_lane_array.sv
module qbs_lane_array #(
   parameter int unsigned AW     = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   input  logic [LANES-1:0]          wr_be_n,
   input  logic                      rd_en,
   input  logic [AW-1:0]             rd_addr,
   output logic [LANES*LANE_W-1:0]   rd_data,
   output logic                      rd_valid
);
   import qbs_pkg::*;

   localparam int unsigned W     = LANES * LANE_W;
   localparam int unsigned DEPTH = 1 << AW;

   logic [W-1:0] merged;
   logic         same_addr;

   assign same_addr = (wr_addr == rd_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned LO = lane_lo(g, LANE_W);
      logic [LANE_W-1:0] store [DEPTH];
      logic              lane_wr;

      assign lane_wr = wr_en & ~wr_be_n[g];

      always_ff @(posedge clk) begin
         if (lane_wr) store[wr_addr] <= wr_data[LO +: LANE_W];
      end

      assign merged[LO +: LANE_W] = (lane_wr && same_addr) ? wr_data[LO +: LANE_W]
                                                          : store[rd_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         rd_data  <= rd_en ? merged : '0;
      end
   end

   // R7
   fwd_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_be_n[0] && rd_en && same_addr)
         |=> rd_data[LANE_W-1:0] == $past(wr_data[LANE_W-1:0]));

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == '0);
endmodule

// File: rtl/quad_burst_sram.sv
module quad_burst_sram #(
   parameter int unsigned AW     = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    k_pos_i,
   input  logic                    rd_n_i,
   input  logic                    wr_n_i,
   input  logic [AW-1:0]           addr_i,
   input  logic [LANES*LANE_W-1:0] d_i,
   input  logic [LANES-1:0]        be_n_i,
   output logic [LANES*LANE_W-1:0] q_o,
   output logic                    q_oe_o
);
   import qbs_pkg::*;

   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("quad_burst_sram: AW must be in 2..12");
   end
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("quad_burst_sram: LANES must be in 1..8");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("quad_burst_sram: LANE_W must be positive");
   end

   logic          wr_beat;
   logic [AW-1:0] wr_addr;
   logic          rd_beat;
   logic [AW-1:0] rd_addr;

   qbs_burst_seq #(.AW(AW), .LEAD(WR_LEAD), .BLEN(BURST_LEN)) u_wr_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .k_pos     (k_pos_i),
      .cmd_n     (wr_n_i),
      .addr      (addr_i),
      .beat_en   (wr_beat),
      .beat_addr (wr_addr)
   );

   qbs_burst_seq #(.AW(AW), .LEAD(RD_LEAD), .BLEN(BURST_LEN)) u_rd_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .k_pos     (k_pos_i),
      .cmd_n     (rd_n_i),
      .addr      (addr_i),
      .beat_en   (rd_beat),
      .beat_addr (rd_addr)
   );

   qbs_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_beat),
      .wr_addr  (wr_addr),
      .wr_data  (d_i),
      .wr_be_n  (be_n_i),
      .rd_en    (rd_beat),
      .rd_addr  (rd_addr),
      .rd_data  (q_o),
      .rd_valid (q_oe_o)
   );

   // R2
   phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      k_pos_i != $past(k_pos_i));

   // R5
   oe_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_oe_o) |=> q_oe_o ##1 q_oe_o ##1 q_oe_o);

   // R2
   neg_phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!k_pos_i && !rd_beat) |=> !$rose(u_rd_seq.lead_q != '0));
endmodule

// File: tb/quad_burst_sram_tb_top.sv
module quad_burst_sram_tb_top;
   localparam int unsigned AW     = 6;
   localparam int unsigned LANES  = 4;
   localparam int unsigned LANE_W = 9;
   localparam int unsigned W      = LANES * LANE_W;
   localparam int unsigned DEPTH  = 1 << AW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             k_pos = 1'b0;
   logic             rd_n = 1'b1;
   logic             wr_n = 1'b1;
   logic [AW-1:0]    addr = '0;
   logic [W-1:0]     d = '0;
   logic [LANES-1:0] be_n = '1;
   logic [W-1:0]     q;
   logic             q_oe;

   quad_burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .k_pos_i(k_pos), .rd_n_i(rd_n), .wr_n_i(wr_n),
      .addr_i(addr), .d_i(d), .be_n_i(be_n), .q_o(q), .q_oe_o(q_oe)
   );

   always #5 clk = ~clk;

   logic [W-1:0]     mdl [DEPTH];
   bit               sr  [16];
   logic [AW-1:0]    sra [16];
   bit               sw  [16];
   logic [AW-1:0]    swa [16];
   bit               rlock = 0, wlock = 0, ph = 0, done = 0;
   int unsigned      n = 0;
   int               errors = 0, checks = 0;
   string            tag = "R1";
   int               be_sel = 0;
   logic [LANES-1:0] be_fix = '0;
   logic [W-1:0]     exp_q = '0;
   bit               exp_oe = 0;

   function automatic logic [W-1:0] merge_lanes(input logic [W-1:0] old,
                                                input logic [W-1:0] nw,
                                                input logic [LANES-1:0] en_n);
      logic [W-1:0] r = old;
      for (int l = 0; l < LANES; l++)
         if (!en_n[l]) r[l*LANE_W +: LANE_W] = nw[l*LANE_W +: LANE_W];
      return r;
   endfunction

   task automatic step(input bit rd, input bit wr, input logic [AW-1:0] a);
      int unsigned      s;
      bit               ra, wa;
      logic [W-1:0]     wd;
      logic [LANES-1:0] wb;
      @(negedge clk);
      s    = n % 16;
      k_pos = ph; rd_n = ~rd; wr_n = ~wr; addr = a;
      wd   = W'({$urandom(), $urandom()});
      wb   = LANES'($urandom());
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin sr[i] = 0; sw[i] = 0; end
         rlock = 0; wlock = 0; exp_q = '0; exp_oe = 0;
      end else begin
         if (ph) begin
            ra = rd && !rlock; wa = wr && !wlock;
            rlock = ra; wlock = wa;
            for (int k = 0; k < 4; k++) begin
               if (ra) begin sr[(n+3+k)%16] = 1; sra[(n+3+k)%16] = a + AW'(k); end
               if (wa) begin sw[(n+2+k)%16] = 1; swa[(n+2+k)%16] = a + AW'(k); end
            end
         end
         if (sw[s]) begin
            if (be_sel == 0) wb = '0;
            else if (be_sel == 2) wb = be_fix;
         end
         if (sr[s]) begin
            exp_q = mdl[sra[s]];
            if (sw[s] && swa[s] == sra[s]) exp_q = merge_lanes(exp_q, wd, wb);
            exp_oe = 1;
         end else begin
            exp_q = '0; exp_oe = 0;
         end
         if (sw[s]) mdl[swa[s]] = merge_lanes(mdl[swa[s]], wd, wb);
         sr[s] = 0; sw[s] = 0;
      end
      d = wd; be_n = wb;
      n++; ph = ~ph;
      @(posedge clk); #1;
      checks++;
      if (q !== exp_q || q_oe !== exp_oe) begin
         errors++;
         $display("FAIL %s: q=%h oe=%b expected q=%h oe=%b", tag, q, q_oe, exp_q, exp_oe);
      end
   endtask

   task automatic cmd(input bit rd, input bit wr, input logic [AW-1:0] a);
      if (!ph) step(0, 0, '0);
      step(rd, wr, a);
   endtask

   task automatic idle(input int c);
      for (int i = 0; i < c; i++) step(0, 0, '0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      // R1: reset state
      tag = "R1"; rst_n = 1'b0; idle(5); rst_n = 1'b1; idle(3);
      // R4: fill the array with full-lane writes
      tag = "R4"; be_sel = 0;
      for (int b = 0; b < int'(DEPTH); b += 4) begin cmd(0, 1, AW'(b)); idle(2); end
      idle(8);
      // R4 R5: write then read on the alternate positive edge
      tag = "R4 R5";
      cmd(1, 0, 6'd5); idle(8);
      cmd(0, 1, 6'd5); cmd(1, 0, 6'd5); idle(8);
      // R2: requests on the negative phase are ignored
      tag = "R2";
      if (ph) step(0, 0, '0);
      step(1, 1, 6'd7); idle(8);
      // R3: same-type requests on back-to-back positive edges
      tag = "R3";
      cmd(1, 0, 6'd8); cmd(1, 0, 6'd12); idle(10);
      cmd(0, 1, 6'd40); cmd(0, 1, 6'd44); idle(4);
      cmd(1, 0, 6'd44); idle(8);
      // R6: lane enable patterns
      tag = "R6"; be_sel = 2;
      be_fix = 4'b1010; cmd(0, 1, 6'd16); idle(3);
      be_fix = 4'b1111; cmd(0, 1, 6'd20); idle(3);
      be_fix = 4'b0110; cmd(0, 1, 6'd24); idle(3);
      be_sel = 0;
      cmd(1, 0, 6'd16); idle(2); cmd(1, 0, 6'd20); idle(2); cmd(1, 0, 6'd24); idle(8);
      // R7: write beat on the same edge as a read beat of the same address
      tag = "R7"; be_sel = 0;
      cmd(1, 0, 6'd30); cmd(0, 1, 6'd31); idle(8);
      be_sel = 2; be_fix = 4'b0101;
      cmd(1, 0, 6'd30); cmd(0, 1, 6'd31); idle(8);
      be_sel = 0;
      cmd(0, 1, 6'd50); cmd(1, 0, 6'd50); idle(8);
      // R9: wrap at the top of the array
      tag = "R9";
      cmd(0, 1, 6'd62); cmd(1, 0, 6'd62); idle(8);
      cmd(1, 0, 6'd0); idle(8);
      // R8: output returns to idle after a burst
      tag = "R8";
      cmd(1, 0, 6'd3); idle(10);
      // R10 R7: random mix, random data on non-beat cycles
      tag = "R7 R10"; be_sel = 1;
      for (int i = 0; i < 3000; i++)
         step(($urandom() % 3) == 0, ($urandom() % 3) == 0, AW'($urandom()));
      idle(10);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: all requirements, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule